// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block settles the result of a two-input floating-point operation when one or both inputs are NaNs. The arithmetic datapath supplies both operand words together with a class code for each one: ordinary number, quiet NaN or signaling NaN. The block returns the NaN the operation should produce and an invalid-operation flag. A 2-bit rule input chooses the propagation policy from four. A default-NaN mode bit replaces the selection with a generated canonical NaN. A polarity bit states whether a set fraction MSB marks a quiet NaN (normal polarity) or a signaling NaN (inverted polarity).

The selection logic is purely combinational. The parameter `REG_OUT` adds one output register stage, and it is on by default. Field widths are parameters. The defaults give a 32-bit word with an 8-bit exponent and a 23-bit fraction.

Top module: `nan_pick`

## Requirements
- R1: With `rule`=0 the block selects `a` if `a` is signaling. Otherwise it selects `b` if `b` is signaling. Otherwise it selects `a` if `a` is a quiet NaN. Otherwise it selects `b`.
- R2: With `rule`=1 the block selects `a` when `a` is any NaN, and `b` otherwise.
- R3: With `rule`=2 the block selects `b` when `b` is any NaN, and `a` otherwise.
- R4: With `rule`=3 the selection works as follows. A signaling NaN paired with a quiet NaN yields the quiet one. Two NaNs of the same kind yield the one whose fraction field is larger as an unsigned value. If the fractions are equal, the operand with sign bit 0 is chosen, and `b` is chosen when both signs are 1. A NaN paired with a non-NaN yields the NaN.
- R5: A selected signaling NaN is output quieted, with sign and exponent unchanged. In normal polarity (`inv_pol`=0) the fraction MSB is set. In inverted polarity the fraction MSB is cleared and the next fraction bit is set. A selected quiet NaN is output unchanged.
- R6: `invalid` is 1 exactly when either class code is 2 (signaling), whatever the values of `dflt_mode` and `rule`.
- R7: With `dflt_mode`=1 the result is the default NaN whatever the operands are. The default NaN has sign 0 and an all-ones exponent. Its fraction is only the MSB set when `inv_pol`=0, and every bit except the MSB set when `inv_pol`=1.
- R8: When neither class code marks a NaN, the result is the default NaN and `invalid` is 0.
- R9: With `REG_OUT`=1 the outputs change one clock after the inputs. During reset they read 0.
- R10: Class codes are 0 for a number, 1 for a quiet NaN and 2 for a signaling NaN. Code 3 is treated as a number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| a_val | input | W | First operand word (sign, exponent, fraction) |
| b_val | input | W | Second operand word |
| a_cls | input | 2 | Class code of the first operand |
| b_cls | input | 2 | Class code of the second operand |
| rule | input | 2 | Propagation rule select |
| dflt_mode | input | 1 | Force the default NaN |
| inv_pol | input | 1 | 1 when a set fraction MSB marks a signaling NaN |
| res | output | W | Chosen NaN result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest case to reach is the tie inside the larger-significand rule. It needs two NaNs of the same kind whose fraction fields match bit for bit and differ only in sign. The bench builds such pairs directly, one with only `a` negative and one with both operands negative, and also covers the signaling-beside-quiet exception that overrides the magnitude compare. Inverted polarity is exercised with operands whose encodings are only NaNs under that polarity, so that quieting must clear a bit as well as set one.

// File: rtl/nan_pick.sv
module nan_pick #(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [EXP_W+FRAC_W:0]         a_val,
  input  logic [EXP_W+FRAC_W:0]         b_val,
  input  logic [1:0]                    a_cls,
  input  logic [1:0]                    b_cls,
  input  logic [1:0]                    rule,
  input  logic                          dflt_mode,
  input  logic                          inv_pol,
  output logic [EXP_W+FRAC_W:0]         res,
  output logic                          invalid
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int QB = FRAC_W - 1;
  localparam logic [1:0] CLS_QNAN = 2'd1;
  localparam logic [1:0] CLS_SNAN = 2'd2;
  localparam logic [1:0] RL_SIG  = 2'd0;
  localparam logic [1:0] RL_FST  = 2'd1;
  localparam logic [1:0] RL_LST  = 2'd2;

  logic a_s, a_q, a_n, b_s, b_q, b_n;
  assign a_s = (a_cls == CLS_SNAN);
  assign a_q = (a_cls == CLS_QNAN);
  assign a_n = a_s | a_q;
  assign b_s = (b_cls == CLS_SNAN);
  assign b_q = (b_cls == CLS_QNAN);
  assign b_n = b_s | b_q;

  logic a_big;
  assign a_big = (a_val[FRAC_W-1:0] > b_val[FRAC_W-1:0]) ||
                 ((a_val[FRAC_W-1:0] == b_val[FRAC_W-1:0]) && !a_val[W-1]);

  logic pick_b;
  always_comb begin
    case (rule)
      RL_SIG: pick_b = !a_s && (b_s || !a_q);
      RL_FST: pick_b = !a_n;
      RL_LST: pick_b = b_n;
      default: begin
        if (a_s)      pick_b = b_q ? 1'b1 : (b_s ? !a_big : 1'b0);
        else if (a_q) pick_b = b_q ? !a_big : 1'b0;
        else          pick_b = 1'b1;
      end
    endcase
  end

  logic [W-1:0] chosen, quieted, dnan, nxt_res;
  logic         chosen_s, nxt_inv;
  assign chosen   = pick_b ? b_val : a_val;
  assign chosen_s = pick_b ? b_s : a_s;

  always_comb begin
    quieted = chosen;
    if (inv_pol) begin
      quieted[QB]   = 1'b0;
      quieted[QB-1] = 1'b1;
    end else begin
      quieted[QB]   = 1'b1;
    end
  end

  assign dnan = {1'b0, {EXP_W{1'b1}}, ~inv_pol, {QB{inv_pol}}};

  assign nxt_res = (dflt_mode || !(a_n || b_n)) ? dnan :
                   chosen_s ? quieted : chosen;
  assign nxt_inv = a_s | b_s;

  generate
    if (REG_OUT) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          res     <= '0;
          invalid <= 1'b0;
          primed  <= 1'b0;
        end else begin
          res     <= nxt_res;
          invalid <= nxt_inv;
          primed  <= 1'b1;
        end
      end

      a_r6_invalid_flag: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (invalid == ($past(a_cls) == CLS_SNAN || $past(b_cls) == CLS_SNAN)));

      a_r5_result_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> (&res[W-2:FRAC_W]) &&
                   ($past(inv_pol) ? (!res[QB] && (res[QB-1:0] != '0)) : res[QB]));

      a_r7_default_canon: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(dflt_mode)) |-> !res[W-1] && (res[QB] == !$past(inv_pol)));

      a_r1_sig_first_a: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(rule) == RL_SIG && !$past(dflt_mode) && $past(a_cls) == CLS_SNAN)
          |-> res[W-2:QB+1] == $past(a_val[W-2:QB+1]) && res[W-1] == $past(a_val[W-1]));
    end else begin : g_comb
      assign res     = nxt_res;
      assign invalid = nxt_inv;
    end
  endgenerate
endmodule

// File: tb/nan_pick_tb.sv
module nan_pick_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a_val = '0, b_val = '0;
  logic [1:0]  a_cls = '0, b_cls = '0, rule = '0;
  logic        dflt_mode = 1'b0, inv_pol = 1'b0;
  logic [31:0] res;
  logic        invalid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nan_pick u_dut (.clk(clk), .rst_n(rst_n), .a_val(a_val), .b_val(b_val),
    .a_cls(a_cls), .b_cls(b_cls), .rule(rule), .dflt_mode(dflt_mode),
    .inv_pol(inv_pol), .res(res), .invalid(invalid));

  task automatic chk(input string tag, input logic [31:0] er, input logic ei);
    checks++;
    if (res !== er || invalid !== ei) begin
      errors++;
      $display("FAIL %s res=%h inv=%b expected res=%h inv=%b", tag, res, invalid, er, ei);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] a, input logic [1:0] ac,
                     input logic [31:0] b, input logic [1:0] bc, input logic [1:0] r,
                     input logic dm, input logic pol, input logic [31:0] er, input logic ei);
    @(negedge clk);
    a_val = a; a_cls = ac; b_val = b; b_cls = bc; rule = r; dflt_mode = dm; inv_pol = pol;
    @(negedge clk);
    chk(tag, er, ei);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9 reset", 32'h0, 1'b0);
  endtask

  task automatic t_sig_first;
    run("R1 b sig", 32'h7FC00001, 2'd1, 32'h7F800005, 2'd2, 2'd0, 0, 0, 32'h7FC00005, 1);
    run("R1 a sig", 32'hFF800009, 2'd2, 32'h7F800005, 2'd2, 2'd0, 0, 0, 32'hFFC00009, 1);
    run("R1 a quiet", 32'h7FC00001, 2'd1, 32'h7FC00002, 2'd1, 2'd0, 0, 0, 32'h7FC00001, 0);
    run("R1 b only", 32'h3F800000, 2'd0, 32'h7FC00002, 2'd1, 2'd0, 0, 0, 32'h7FC00002, 0);
  endtask

  task automatic t_first_last;
    run("R2 b nan", 32'h3F800000, 2'd0, 32'h7F800005, 2'd2, 2'd1, 0, 0, 32'h7FC00005, 1);
    run("R2 a over sig b", 32'h7FC00001, 2'd1, 32'h7F800005, 2'd2, 2'd1, 0, 0, 32'h7FC00001, 1);
    run("R3 b quiet", 32'h7FC00001, 2'd1, 32'h7FC00002, 2'd1, 2'd2, 0, 0, 32'h7FC00002, 0);
    run("R3 a sig", 32'h7F800005, 2'd2, 32'h40000000, 2'd0, 2'd2, 0, 0, 32'h7FC00005, 1);
  endtask

  task automatic t_larger;
    run("R4 quiet beats sig", 32'h7F800005, 2'd2, 32'h7FC00001, 2'd1, 2'd3, 0, 0, 32'h7FC00001, 1);
    run("R4 larger quiet", 32'h7FC00010, 2'd1, 32'h7FC00020, 2'd1, 2'd3, 0, 0, 32'h7FC00020, 0);
    run("R4 larger sig", 32'h7F800030, 2'd2, 32'h7F800020, 2'd2, 2'd3, 0, 0, 32'h7FC00030, 1);
    run("R4 tie positive", 32'hFFC00004, 2'd1, 32'h7FC00004, 2'd1, 2'd3, 0, 0, 32'h7FC00004, 0);
    run("R4 tie both neg", 32'hFFC00004, 2'd1, 32'hFFC00004, 2'd1, 2'd3, 0, 0, 32'hFFC00004, 0);
    run("R4 sig vs num", 32'h7F800007, 2'd2, 32'h3F800000, 2'd0, 2'd3, 0, 0, 32'h7FC00007, 1);
  endtask

  task automatic t_default;
    run("R7 dflt normal", 32'h7F800005, 2'd2, 32'h7FC00001, 2'd1, 2'd0, 1, 0, 32'h7FC00000, 1);
    run("R7 dflt inverted", 32'h7F800007, 2'd1, 32'h3F800000, 2'd0, 2'd1, 1, 1, 32'h7FBFFFFF, 0);
    run("R8 no nan", 32'h3F800000, 2'd0, 32'h40000000, 2'd0, 2'd2, 0, 0, 32'h7FC00000, 0);
    run("R10 code3 number", 32'h7FC00001, 2'd3, 32'h7FC00002, 2'd3, 2'd1, 0, 0, 32'h7FC00000, 0);
  endtask

  task automatic t_inverted;
    run("R5 inv quieting", 32'h7FC00003, 2'd2, 32'h3F800000, 2'd0, 2'd0, 0, 1, 32'h7FA00003, 1);
    run("R5 inv quiet kept", 32'h7F800007, 2'd1, 32'h7FC00003, 2'd0, 2'd1, 0, 1, 32'h7F800007, 0);
    run("R6 flag on b", 32'h7FC00001, 2'd1, 32'h7F800005, 2'd2, 2'd2, 0, 0, 32'h7FC00005, 1);
  endtask

  task automatic t_latency;
    @(negedge clk);
    a_val = 32'h7FC00011; a_cls = 2'd1; b_val = 32'h0; b_cls = 2'd0; rule = 2'd1;
    dflt_mode = 0; inv_pol = 0;
    @(posedge clk);
    #1;
    a_val = 32'h3F800000; a_cls = 2'd0;
    @(negedge clk);
    chk("R9 one-clock latency", 32'h7FC00011, 0);
    @(negedge clk);
    chk("R9 next cycle", 32'h7FC00000, 0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_sig_first();
    t_first_last();
    t_larger();
    t_default();
    t_inverted();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule